// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial-peripheral slave that gives a host read and write access to four 8-bit configuration registers of a dual-channel converter. The registers hold interface control, power-down, data-format control and I-channel fine gain. Their contents leave the block as parallel fields that drive the datapath.

The slave works in the system clock domain. It synchronises the serial clock, chip select and data input, and it detects the serial clock edges. Each transaction is one instruction followed by one data byte. The instruction is a read flag (1 = read), two reserved bits and an address. The short form is 8 bits long with a 5-bit address. The long form is 16 bits long with a 13-bit address.

Two settings in the control register can be changed at run time: the shift order and the address width. A third control bit is a soft reset. It holds every other register at its default value until the host clears it.

Top module: `cfg_spi_slave`

## Requirements
- R1: After rst_ni the registers read back as follows: address 0 gives 0x00, address 1 gives 0x40, address 2 gives 0x34 and address 3 gives 0x00.
- R2: The bus runs in mode 0. SDI is sampled on rising SCLK and SDO changes on falling SCLK. An instruction carries the read flag as its most significant bit (1 = read), then two ignored bits, then the address. One data byte follows the instruction. SDO is 0 outside the data byte of a read.
- R3: Reading a defined bit returns the value last written to it. Undefined bits read 0 and ignore writes. These are bits 7 and 3..0 of address 0, bit 6 of address 2 and bits 7..6 of address 3.
- R4: Address 0 bit 6 set to 1 selects LSB-first order. In that order both the instruction word and the data byte move bit 0 first. At 0 they move MSB first.
- R5: Address 0 bit 4 set to 1 selects a 16-bit instruction with a 13-bit address. At 0 the instruction is 8 bits with a 5-bit address.
- R6: A new shift order or address width applies from the next chip-select assertion onward.
- R7: Writing 1 to address 0 bit 5 loads defaults into addresses 1 to 3 and holds them there. Writes to those addresses are ignored until a later write clears the bit. Address 0 keeps its written value.
- R8: Address 1 bit 6 is read-only. It reads as the inverse of address 1 bit 7.
- R9: Address 1 bit 5 is a global power-down. While it is 1, the five off outputs (Q output, I output, Q clock, I clock, reference) are forced to 1. Readback and the serial interface keep working.
- R10: Addresses other than 0 to 3 read 0x00, and writes to them change nothing.
- R11: If chip select deasserts before the last data bit, the transfer is dropped and nothing is written.
- R12: The parallel outputs follow these register bits: address 0 bits 6/5/4 drive LSB-first, soft reset and long address. Address 1 bits 7/5/4/3/2/1/0 drive LDO-off, power-down, Q out off, I out off, Q clock off, I clock off and reference off. Address 2 drives data_ctrl_o. Address 3 bits 5..0 drive i_gain_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial read data to host |
| lsb_first_o | output | 1 | Shift order setting |
| long_addr_o | output | 1 | Address width setting |
| soft_rst_o | output | 1 | Soft reset active |
| ldo_off_o | output | 1 | Regulator off request |
| pwr_down_o | output | 1 | Global power-down |
| q_out_off_o | output | 1 | Q output current off |
| i_out_off_o | output | 1 | I output current off |
| q_clk_off_o | output | 1 | Q clock off |
| i_clk_off_o | output | 1 | I clock off |
| ref_off_o | output | 1 | Internal reference off |
| data_ctrl_o | output | 8 | Data-format control byte |
| i_gain_o | output | 6 | I-channel fine gain |

## Verification
The bench goes after four kinds of mistake.

- A mode switch written inside a transaction. The host then sends frames in the new order and width. A slave that applied the switch at once, or that ignored it, would decode the wrong address and return wrong readback data.
- The soft reset. The bench tries writes while the soft reset is held and again after release. A slave that released on its own, or that wiped the control register, would show changed data or a lost mode.
- A chip-select abort and an unmapped address. A design that committed early, or that aliased upper address bits, would corrupt a real register. The bench checks the long 13-bit address path for this aliasing.
- The status bit and the power-down. A per-cycle comparison against a behavioural register model catches a status bit that does not track the regulator control, and a power-down that fails to force the off outputs.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int unsigned DW = 8;

  localparam logic [7:0] CTRL_MASK = 8'h70;
  localparam logic [7:0] PD_MASK   = 8'hBF;
  localparam logic [7:0] DC_MASK   = 8'hBF;
  localparam logic [7:0] GAIN_MASK = 8'h3F;

  localparam logic [7:0] PD_RST   = 8'h00;
  localparam logic [7:0] DC_RST   = 8'h34;
  localparam logic [7:0] GAIN_RST = 8'h00;

  localparam int unsigned CTRL_LSB_BIT  = 6;
  localparam int unsigned CTRL_SOFT_BIT = 5;
  localparam int unsigned CTRL_LONG_BIT = 4;
  localparam int unsigned PD_LDO_BIT    = 7;
  localparam int unsigned PD_STAT_BIT   = 6;
  localparam int unsigned PD_ALL_BIT    = 5;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_PD   = 2'd1,
    RA_DC   = 2'd2,
    RA_GAIN = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] ctrl;
    logic [7:0] pd;
    logic [7:0] dc;
    logic [7:0] gain;
  } cfg_regs_t;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_spi_engine.sv
module cfg_spi_engine
  import cfg_spi_pkg::*;
#(
  parameter int unsigned SHORT_AW = 5,
  parameter int unsigned LONG_AW  = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               sdi_i,
  input  logic               lsb_first_i,
  input  logic               long_addr_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic [LONG_AW-1:0] addr_o,
  output logic               wr_en_o,
  output logic [DW-1:0]      wr_data_o,
  output logic               sdo_o
);
  localparam int unsigned SHORT_IW = SHORT_AW + 3;
  localparam int unsigned LONG_IW  = LONG_AW + 3;
  localparam int unsigned TOT      = LONG_IW + DW;
  localparam int unsigned CNT_W    = $clog2(TOT + 1);
  localparam int unsigned SH_IW    = $clog2(LONG_IW);
  localparam int unsigned DB_W     = $clog2(DW);

  logic               sclk_q, lsb_q, long_q, rd_q, sdo_q, wr_en_q;
  logic [CNT_W-1:0]   cnt_q, instr_w, didx, msb_idx;
  logic [LONG_IW-1:0] sh_q, sh_nxt;
  logic [DW-1:0]      dsh_q, dsh_nxt, wr_data_q;
  logic [LONG_AW-1:0] addr_q, addr_nxt;
  logic [DB_W-1:0]    dbit;
  logic               rise, fall, in_instr, in_data, last_instr, last_data, rw_nxt;

  assign rise       = sclk_i & ~sclk_q;
  assign fall       = ~sclk_i & sclk_q;
  assign instr_w    = long_q ? CNT_W'(LONG_IW) : CNT_W'(SHORT_IW);
  assign didx       = cnt_q - instr_w;
  assign msb_idx    = instr_w - CNT_W'(1) - cnt_q;
  assign in_instr   = cnt_q < instr_w;
  assign in_data    = !in_instr && (cnt_q < instr_w + CNT_W'(DW));
  assign last_instr = cnt_q == instr_w - CNT_W'(1);
  assign last_data  = cnt_q == instr_w + CNT_W'(DW - 1);
  assign dbit       = lsb_q ? didx[DB_W-1:0] : DB_W'(DW - 1) - didx[DB_W-1:0];

  always_comb begin
    sh_nxt = sh_q;
    if (in_instr) begin
      if (lsb_q) sh_nxt[cnt_q[SH_IW-1:0]]   = sdi_i;
      else       sh_nxt[msb_idx[SH_IW-1:0]] = sdi_i;
    end
    dsh_nxt = dsh_q;
    if (in_data) dsh_nxt[dbit] = sdi_i;
  end

  assign rw_nxt   = long_q ? sh_nxt[LONG_IW-1] : sh_nxt[SHORT_IW-1];
  assign addr_nxt = long_q ? sh_nxt[LONG_AW-1:0] : LONG_AW'(sh_nxt[SHORT_AW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      lsb_q     <= 1'b0;
      long_q    <= 1'b0;
      rd_q      <= 1'b0;
      sdo_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      dsh_q     <= '0;
      wr_data_q <= '0;
      addr_q    <= '0;
    end else begin
      sclk_q  <= sclk_i;
      wr_en_q <= 1'b0;
      if (cs_n_i) begin
        // modes are sampled only while deselected
        cnt_q  <= '0;
        lsb_q  <= lsb_first_i;
        long_q <= long_addr_i;
        sdo_q  <= 1'b0;
        rd_q   <= 1'b0;
      end else begin
        if (rise && (in_instr || in_data)) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (in_instr) begin
            sh_q <= sh_nxt;
            if (last_instr) begin
              rd_q   <= rw_nxt;
              addr_q <= addr_nxt;
            end
          end else begin
            dsh_q <= dsh_nxt;
            if (last_data && !rd_q) begin
              wr_en_q   <= 1'b1;
              wr_data_q <= dsh_nxt;
            end
          end
        end
        if (fall) sdo_q <= (in_data && rd_q) ? rd_data_i[dbit] : 1'b0;
      end
    end
  end

  assign addr_o    = addr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign sdo_o     = sdo_q;

  a_r6_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && $past(!cs_n_i)) |-> ($stable(lsb_q) && $stable(long_q)));
  a_r2_sdo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !sdo_o);
  a_r11_write_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> $past(!cs_n_i));
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(TOT));
endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
  import cfg_spi_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output cfg_regs_t     regs_o
);
  cfg_regs_t regs_q;
  logic      hit_ctrl, soft_set;

  assign hit_ctrl = wr_en_i && (addr_i == AW'(RA_CTRL));
  assign soft_set = hit_ctrl && wr_data_i[CTRL_SOFT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q.ctrl <= '0;
      regs_q.pd   <= PD_RST;
      regs_q.dc   <= DC_RST;
      regs_q.gain <= GAIN_RST;
    end else begin
      if (hit_ctrl) regs_q.ctrl <= wr_data_i & CTRL_MASK;
      if (regs_q.ctrl[CTRL_SOFT_BIT] || soft_set) begin
        regs_q.pd   <= PD_RST;
        regs_q.dc   <= DC_RST;
        regs_q.gain <= GAIN_RST;
      end else if (wr_en_i) begin
        if (addr_i == AW'(RA_PD))   regs_q.pd   <= wr_data_i & PD_MASK;
        if (addr_i == AW'(RA_DC))   regs_q.dc   <= wr_data_i & DC_MASK;
        if (addr_i == AW'(RA_GAIN)) regs_q.gain <= wr_data_i & GAIN_MASK;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == AW'(RA_CTRL)) rd_data_o = regs_q.ctrl;
    if (addr_i == AW'(RA_PD)) begin
      rd_data_o              = regs_q.pd;
      rd_data_o[PD_STAT_BIT] = ~regs_q.pd[PD_LDO_BIT];
    end
    if (addr_i == AW'(RA_DC))   rd_data_o = regs_q.dc;
    if (addr_i == AW'(RA_GAIN)) rd_data_o = regs_q.gain;
  end

  assign regs_o = regs_q;

  a_r7_soft_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q.ctrl[CTRL_SOFT_BIT] |-> (regs_q.pd == PD_RST && regs_q.dc == DC_RST
                                    && regs_q.gain == GAIN_RST));
  a_r7_ctrl_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hit_ctrl) |-> $stable(regs_q.ctrl));
  a_r3_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((regs_q.ctrl & ~CTRL_MASK) == '0) && ((regs_q.gain & ~GAIN_MASK) == '0)
    && !regs_q.dc[6] && !regs_q.pd[PD_STAT_BIT]);
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfg_spi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SHORT_AW    = 5,
  parameter int unsigned LONG_AW     = 13,
  parameter int unsigned GAIN_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              lsb_first_o,
  output logic              long_addr_o,
  output logic              soft_rst_o,
  output logic              ldo_off_o,
  output logic              pwr_down_o,
  output logic              q_out_off_o,
  output logic              i_out_off_o,
  output logic              q_clk_off_o,
  output logic              i_clk_off_o,
  output logic              ref_off_o,
  output logic [DW-1:0]     data_ctrl_o,
  output logic [GAIN_W-1:0] i_gain_o
);
  logic               sclk_s, cs_n_s, sdi_s, wr_en;
  logic [LONG_AW-1:0] addr;
  logic [DW-1:0]      wr_data, rd_data;
  cfg_regs_t          regs;
  logic               pdn;

  cfg_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  cfg_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_n_s));
  cfg_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdi_i), .q_o(sdi_s));

  cfg_spi_engine #(.SHORT_AW(SHORT_AW), .LONG_AW(LONG_AW)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_s),
    .cs_n_i      (cs_n_s),
    .sdi_i       (sdi_s),
    .lsb_first_i (regs.ctrl[CTRL_LSB_BIT]),
    .long_addr_i (regs.ctrl[CTRL_LONG_BIT]),
    .rd_data_i   (rd_data),
    .addr_o      (addr),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .sdo_o       (sdo_o)
  );

  cfg_spi_regfile #(.AW(LONG_AW)) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .regs_o    (regs)
  );

  assign pdn         = regs.pd[PD_ALL_BIT];
  assign lsb_first_o = regs.ctrl[CTRL_LSB_BIT];
  assign long_addr_o = regs.ctrl[CTRL_LONG_BIT];
  assign soft_rst_o  = regs.ctrl[CTRL_SOFT_BIT];
  assign ldo_off_o   = regs.pd[PD_LDO_BIT];
  assign pwr_down_o  = pdn;
  assign q_out_off_o = regs.pd[4] | pdn;
  assign i_out_off_o = regs.pd[3] | pdn;
  assign q_clk_off_o = regs.pd[2] | pdn;
  assign i_clk_off_o = regs.pd[1] | pdn;
  assign ref_off_o   = regs.pd[0] | pdn;
  assign data_ctrl_o = regs.dc;
  assign i_gain_o    = regs.gain[GAIN_W-1:0];

  a_r9_pdn_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> (q_out_off_o && i_out_off_o && q_clk_off_o && i_clk_off_o && ref_off_o));
endmodule

// File: tb/cfg_spi_slave_bench.sv
module cfg_spi_slave_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, lsb_o, long_o, soft_o, ldo_o, pdn_o, qo_o, io_o, qc_o, ic_o, rf_o;
  logic [7:0] dc_o;
  logic [5:0] gain_o;

  int n_chk = 0, n_err = 0;
  bit chk_en = 1'b0, done = 1'b0;
  logic [7:0] m_ctrl = 8'h00, m_pd = 8'h00, m_dc = 8'h34, m_gain = 8'h00;

  always #5 clk = ~clk;

  cfg_spi_slave u_cfg_spi_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi), .sdo_o(sdo),
    .lsb_first_o(lsb_o), .long_addr_o(long_o), .soft_rst_o(soft_o), .ldo_off_o(ldo_o),
    .pwr_down_o(pdn_o), .q_out_off_o(qo_o), .i_out_off_o(io_o), .q_clk_off_o(qc_o),
    .i_clk_off_o(ic_o), .ref_off_o(rf_o), .data_ctrl_o(dc_o), .i_gain_o(gain_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_pd | {1'b0, ~m_pd[7], 6'b0};
      2: return m_dc;
      3: return m_gain;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input int a, input logic [7:0] d);
    if (a == 0) begin
      m_ctrl = d & 8'h70;
      if (d[5]) begin m_pd = 8'h00; m_dc = 8'h34; m_gain = 8'h00; end
    end else if (!m_ctrl[5]) begin
      case (a)
        1: m_pd = d & 8'hBF;
        2: m_dc = d & 8'hBF;
        3: m_gain = d & 8'h3F;
        default: ;
      endcase
    end
  endtask

  function automatic logic [23:0] model_out();
    logic p;
    p = m_pd[5];
    return {m_ctrl[6], m_ctrl[4], m_ctrl[5], m_pd[7], p, m_pd[4] | p, m_pd[3] | p,
            m_pd[2] | p, m_pd[1] | p, m_pd[0] | p, m_dc, m_gain[5:0]};
  endfunction

  // R12 R9 R1: per-clock comparison of parallel outputs against the model
  always @(negedge clk) begin
    if (chk_en && !done)
      chk("R12 outputs", {8'h0, lsb_o, long_o, soft_o, ldo_o, pdn_o, qo_o, io_o, qc_o, ic_o, rf_o,
                          dc_o, gain_o}, {8'h0, model_out()});
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits < 0 sends a whole frame; otherwise abort after nbits bits (R11)
  task automatic xfer(input bit rd, input int addr, input logic [7:0] wd, input int nbits,
                      output logic [7:0] rdv);
    int iw, total;
    bit lsb, lng;
    logic [15:0] w;
    chk_en = 1'b0;
    lsb = m_ctrl[6];
    lng = m_ctrl[4];
    iw = lng ? 16 : 8;
    w = lng ? ({15'b0, rd} << 15) | 16'(addr & 13'h1FFF) : ({15'b0, rd} << 7) | 16'(addr & 5'h1F);
    total = (nbits < 0) ? iw + 8 : nbits;
    rdv = 8'h00;
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < total; k++) begin
      int j;
      j = k - iw;
      if (k < iw) sdi = lsb ? w[k] : w[iw-1-k];
      else        sdi = rd ? 1'b0 : (lsb ? wd[j] : wd[7-j]);
      wait_clk(HALF);
      if (k >= iw) rdv[lsb ? j : 7 - j] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
    if (nbits < 0 && !rd) model_wr(addr, wd);
    chk_en = 1'b1;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer(1'b0, a, d, -1, dummy);
  endtask

  task automatic rd_chk(input string tag, input int a);
    logic [7:0] v;
    xfer(1'b1, a, 8'h00, -1, v);
    chk(tag, {24'h0, v}, {24'h0, model_rd(a)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    chk_en = 1'b1;
    wait_clk(4);
    // R1 R8: reset readback
    chk("R1 sdo idle", {31'h0, sdo}, 32'h0);
    rd_chk("R1 addr0", 0);
    rd_chk("R1 R8 addr1", 1);
    chk("R1 addr1 lit", {24'h0, model_rd(1)}, 32'h40);
    rd_chk("R1 addr2", 2);
    rd_chk("R1 addr3", 3);
    // R2 R3: write and readback, undefined bits drop
    wr(3, 8'hFF); rd_chk("R3 gain", 3);
    chk("R3 gain lit", {24'h0, model_rd(3)}, 32'h3F);
    wr(2, 8'hFF); rd_chk("R3 dc", 2);
    wr(2, 8'h5A); rd_chk("R2 dc pattern", 2);
    wr(0, 8'h8F); rd_chk("R3 ctrl undef", 0);
    // R9 R8: power-down forces off outputs, status tracks LDO bit
    wr(1, 8'h20); rd_chk("R9 pdn readback", 1);
    wait_clk(2);
    chk("R9 off forced", {27'h0, qo_o, io_o, qc_o, ic_o, rf_o}, 32'h1F);
    wr(3, 8'h2A); rd_chk("R9 spi alive", 3);
    wr(1, 8'h80); rd_chk("R8 ldo off status", 1);
    wr(1, 8'h15); rd_chk("R8 R12 addr1", 1);
    // R10: unmapped address
    wr(4, 8'hAA); rd_chk("R10 read 4", 4);
    wr(31, 8'h55); rd_chk("R10 read 31", 31);
    rd_chk("R10 addr3 intact", 3);
    rd_chk("R10 addr2 intact", 2);
    // R4 R6: switch to LSB first; next frame uses new order
    wr(0, 8'h40);
    rd_chk("R4 R6 lsb addr2", 2);
    wr(3, 8'h0B); rd_chk("R4 lsb gain", 3);
    // R5 R6: long addressing, switched from lsb-first frame
    wr(0, 8'h10);
    rd_chk("R5 long addr3", 3);
    wr(13'h1003, 8'hFF); rd_chk("R5 R10 long 0x1003", 13'h1003);
    rd_chk("R5 no alias", 3);
    wr(0, 8'h50); wr(1, 8'h04); rd_chk("R4 R5 long lsb", 1);
    // R7: soft reset holds defaults, keeps ctrl
    wr(0, 8'h30);
    rd_chk("R7 ctrl kept", 0);
    rd_chk("R7 dc default", 2);
    wr(3, 8'h11); rd_chk("R7 write ignored", 3);
    wr(0, 8'h00);
    rd_chk("R7 released dc", 2);
    wr(3, 8'h22); rd_chk("R7 write after release", 3);
    // R11: aborted frame writes nothing
    xfer(1'b0, 3, 8'h3C, 12, v);
    rd_chk("R11 abort", 3);
    xfer(1'b0, 2, 8'h01, 15, v);
    rd_chk("R11 abort last bit", 2);
    chk("R2 sdo idle end", {31'h0, sdo}, 32'h0);
    wait_clk(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule